// File: doc/BRIEF.md
# Frame-Locked Sample Clock Prescaler with Standby Control

This block runs entirely on a master clock whose rate is not known in advance. It works out that rate by counting master clock cycles between successive rising edges of a frame sync input. It compares the count with a fixed set of eight nominal cycle counts, which stand for master clocks of 256 kHz to 4.8 MHz against an 8 kHz frame. Once a count matches, the block locks. It then issues one sample strobe per frame and exactly 32 evenly spread ticks per frame. A fractional accumulator spreads the ticks, so counts that 32 does not divide, such as 193 and 600, still give 32 ticks.

The block also keeps the power state of the channel. It drops into standby in two cases: the power-up input is pulled low, or frame sync goes missing for longer than the locked frame plus a small margin. It returns to service on the first frame sync edge that arrives while power-up is high. The permission for the transmit output is withheld until two further frame sync edges have been seen.

Top module: `fl_prescaler`

## Requirements
- R1: While rst_ni is low, standby_o is 1 and tick_o, strobe_o, locked_o and tx_en_o are all 0.
- R2: A frame sync edge is a cycle in which fsync_i is 1 and was 0 in the previous cycle. The measured period is the number of clock edges from one edge to the next. The first edge after reset, after power-down or after a counter overflow at 1023 only starts a measurement. A measured period sets locked_o and rate_o in the cycle after the closing edge. The rate_o codes 0 to 7 stand for 32, 64, 192, 193, 256, 320, 512 and 600 cycles. An exact match takes precedence. Otherwise a code within one cycle is taken, and the lowest code wins.
- R3: A measured period that is not within one cycle of any nominal count clears locked_o, and no tick or strobe follows in that frame.
- R4: strobe_o is high for exactly one cycle: the cycle after each frame sync edge that leaves the block locked.
- R5: In a locked frame of nominal count N, tick_o is high in the cycle after the frame sync edge. It is also high k cycles later for each k at which floor(32k/N) increases.
- R6: No more than 32 ticks appear between two frame sync edges, even when the frame runs longer than N.
- R7: When locked at nominal count N, if no frame sync edge arrives within N+8 clock edges after the last one, locked_o falls to 0 and standby_o rises to 1 after edge N+8.
- R8: While pwr_up_i is low, the cycle after each edge shows standby_o at 1 and locked_o, tx_en_o, tick_o and strobe_o at 0. Any measurement in progress is discarded.
- R9: In standby, a frame sync edge with pwr_up_i high clears standby_o in the next cycle.
- R10: tx_en_o rises after the second frame sync edge that follows the wake-up edge. It stays high until standby is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, any of the supported rates |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, synchronous to clk_i |
| pwr_up_i | input | 1 | Power-up request; low forces standby |
| tick_o | output | 1 | Internal tick, 32 per locked frame |
| strobe_o | output | 1 | One-cycle sample strobe per locked frame |
| locked_o | output | 1 | A supported rate has been measured |
| rate_o | output | 3 | Code of the last locked nominal count |
| standby_o | output | 1 | Channel is in low power standby |
| tx_en_o | output | 1 | Transmit output may leave high impedance |

## Verification
The assertions assume that fsync_i and pwr_up_i are already synchronous to clk_i. They also assume that a frame sync pulse is followed by at least one low cycle before the next edge. A pulse held high for several cycles still counts as a single edge. The bench changes every input on the falling clock edge. It shapes frame sync as single-cycle pulses separated by a chosen period, and it never toggles pwr_up_i faster than once per cycle. Period choices sweep every supported count at N, N-1, N+1, N+5 and N+21. These cover exact and neighbouring matches, rejection, the tick cap and the loss timeout.

// File: rtl/fl_prescaler_pkg.sv
package fl_prescaler_pkg;

  localparam int NUM_RATES = 8;
  localparam int IDX_W     = $clog2(NUM_RATES);

  // nominal master clock cycles per 8 kHz frame, code order is the rate_o encoding
  function automatic int unsigned rate_count(input int idx);
    case (idx)
      0:       return 32;
      1:       return 64;
      2:       return 192;
      3:       return 193;
      4:       return 256;
      5:       return 320;
      6:       return 512;
      default: return 600;
    endcase
  endfunction

endpackage

// File: rtl/fl_frame_meter.sv
module fl_frame_meter
  import fl_prescaler_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int TOL    = 1,
  parameter int MARGIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_up_i,
  input  logic             rise_i,
  output logic             lock_d_o,
  output logic             start_o,
  output logic             lost_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] n_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W+1:0] TOL_W    = (CNT_W+2)'(TOL);
  localparam logic [CNT_W+1:0] MARGIN_W = (CNT_W+2)'(MARGIN);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             locked_q;
  logic [CNT_W-1:0] n_q;
  logic [IDX_W-1:0] idx_q;

  logic [CNT_W+1:0] meas_w;
  logic [CNT_W+1:0] nom_w;
  logic             exact_hit, near_hit, match_ok;
  logic [IDX_W-1:0] exact_sel, near_sel, match_idx;

  assign meas_w = {2'b00, cnt_q} + (CNT_W+2)'(1);

  // descending scan so the lowest code wins within each class
  always_comb begin
    exact_hit = 1'b0;
    near_hit  = 1'b0;
    exact_sel = '0;
    near_sel  = '0;
    nom_w     = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      nom_w = (CNT_W+2)'(rate_count(i));
      if (meas_w == nom_w) begin
        exact_hit = 1'b1;
        exact_sel = IDX_W'(i);
      end
      if ((meas_w + TOL_W >= nom_w) && (meas_w <= nom_w + TOL_W)) begin
        near_hit = 1'b1;
        near_sel = IDX_W'(i);
      end
    end
  end

  assign match_ok  = exact_hit | near_hit;
  assign match_idx = exact_hit ? exact_sel : near_sel;

  assign start_o = pwr_up_i & rise_i & armed_q & match_ok;
  assign lost_o  = pwr_up_i & ~rise_i & locked_q &
                   (meas_w >= ({2'b00, n_q} + MARGIN_W));

  always_comb begin
    if (!pwr_up_i)   lock_d_o = 1'b0;
    else if (rise_i) lock_d_o = start_o;
    else if (lost_o) lock_d_o = 1'b0;
    else             lock_d_o = locked_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      n_q      <= '0;
      idx_q    <= '0;
    end else begin
      locked_q <= lock_d_o;
      if (!pwr_up_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (rise_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (start_o) begin
          n_q   <= CNT_W'(rate_count(int'(match_idx)));
          idx_q <= match_idx;
        end
      end else if (cnt_q == CNT_MAX) begin
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign locked_o = locked_q;
  assign n_o      = n_q;
  assign idx_o    = idx_q;

  AST_LOCK_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(rise_i && pwr_up_i)); // R2

  AST_NOMINAL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> (n_q >= CNT_W'(rate_count(0)))); // R2

endmodule

// File: rtl/fl_tick_gen.sv
module fl_tick_gen #(
  parameter int CNT_W = 10,
  parameter int TICKS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             tick_o,
  output logic             strobe_o
);

  localparam int           TC_W    = $clog2(TICKS + 1);
  localparam logic [CNT_W:0] TICKS_W = (CNT_W+1)'(TICKS);
  localparam logic [TC_W-1:0] TICKS_C = TC_W'(TICKS);

  logic [CNT_W-1:0] acc_q;
  logic [TC_W-1:0]  tcnt_q;
  logic [CNT_W:0]   sum_w;
  logic             wrap_w;

  assign sum_w  = {1'b0, acc_q} + TICKS_W;
  assign wrap_w = sum_w >= {1'b0, n_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      tcnt_q   <= '0;
      tick_o   <= 1'b0;
      strobe_o <= 1'b0;
    end else if (start_i) begin
      acc_q    <= '0;
      tcnt_q   <= TC_W'(1);
      tick_o   <= 1'b1;
      strobe_o <= 1'b1;
    end else if (en_i) begin
      strobe_o <= 1'b0;
      if (wrap_w) begin
        acc_q <= CNT_W'(sum_w - {1'b0, n_i});
        if (tcnt_q < TICKS_C) begin
          tick_o <= 1'b1;
          tcnt_q <= tcnt_q + TC_W'(1);
        end else begin
          tick_o <= 1'b0;
        end
      end else begin
        acc_q  <= CNT_W'(sum_w);
        tick_o <= 1'b0;
      end
    end else begin
      tick_o   <= 1'b0;
      strobe_o <= 1'b0;
    end
  end

  AST_TICK_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt_q <= TICKS_C); // R6

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i) |-> (acc_q < n_i)); // R5

endmodule

// File: rtl/fl_power_ctrl.sv
module fl_power_ctrl #(
  parameter int TX_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_i,
  input  logic rise_i,
  input  logic lost_i,
  output logic standby_o,
  output logic tx_en_o
);

  localparam int             FC_W  = $clog2(TX_FRAMES + 1);
  localparam logic [FC_W-1:0] FC_MAX = FC_W'(TX_FRAMES);

  logic            sb_q;
  logic [FC_W-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb_q   <= 1'b1;
      fcnt_q <= '0;
    end else if (!pwr_up_i || lost_i) begin
      sb_q   <= 1'b1;
      fcnt_q <= '0;
    end else if (rise_i) begin
      if (sb_q) begin
        sb_q   <= 1'b0;
        fcnt_q <= '0;
      end else if (fcnt_q != FC_MAX) begin
        fcnt_q <= fcnt_q + FC_W'(1);
      end
    end
  end

  assign standby_o = sb_q;
  assign tx_en_o   = ~sb_q & (fcnt_q == FC_MAX);

  AST_PWR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> (standby_o && !tx_en_o)); // R8

  AST_TX_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> !standby_o); // R10

  AST_WAKE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) |-> $past(rise_i && pwr_up_i)); // R9

endmodule

// File: rtl/fl_prescaler.sv
module fl_prescaler
  import fl_prescaler_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TICKS     = 32,
  parameter int TOL       = 1,
  parameter int MARGIN    = 8,
  parameter int TX_FRAMES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             pwr_up_i,
  output logic             tick_o,
  output logic             strobe_o,
  output logic             locked_o,
  output logic [IDX_W-1:0] rate_o,
  output logic             standby_o,
  output logic             tx_en_o
);

  logic             fs_q;
  logic             rise_w;
  logic             lock_d_w, start_w, lost_w;
  logic [CNT_W-1:0] n_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= 1'b0;
    else         fs_q <= fsync_i;
  end

  assign rise_w = fsync_i & ~fs_q;

  fl_frame_meter #(
    .CNT_W (CNT_W),
    .TOL   (TOL),
    .MARGIN(MARGIN)
  ) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_up_i(pwr_up_i),
    .rise_i  (rise_w),
    .lock_d_o(lock_d_w),
    .start_o (start_w),
    .lost_o  (lost_w),
    .locked_o(locked_o),
    .n_o     (n_w),
    .idx_o   (rate_o)
  );

  fl_tick_gen #(
    .CNT_W(CNT_W),
    .TICKS(TICKS)
  ) u_ticks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (lock_d_w),
    .start_i (start_w),
    .n_i     (n_w),
    .tick_o  (tick_o),
    .strobe_o(strobe_o)
  );

  fl_power_ctrl #(
    .TX_FRAMES(TX_FRAMES)
  ) u_power (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_up_i (pwr_up_i),
    .rise_i   (rise_w),
    .lost_i   (lost_w),
    .standby_o(standby_o),
    .tx_en_o  (tx_en_o)
  );

  AST_TICK_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> locked_o); // R5

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R4

  AST_STROBE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (tick_o && locked_o)); // R4

  AST_LOCK_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !standby_o); // R9

endmodule

// File: tb/fl_prescaler_bench.sv
module fl_prescaler_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fsync_i = 1'b0;
  logic       pwr_up_i = 1'b1;
  logic       tick_o, strobe_o, locked_o, standby_o, tx_en_o;
  logic [2:0] rate_o;

  fl_prescaler u_fl_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .pwr_up_i (pwr_up_i),
    .tick_o   (tick_o),
    .strobe_o (strobe_o),
    .locked_o (locked_o),
    .rate_o   (rate_o),
    .standby_o(standby_o),
    .tx_en_o  (tx_en_o)
  );

  always #5 clk_i = ~clk_i;

  int total = 0;
  int bad   = 0;

  // expected state derived from the requirements
  bit m_fsq, m_armed, m_locked, m_sb;
  int m_cnt, m_n, m_idx, m_k, m_t, m_r;

  function automatic int nom(input int i);
    case (i)
      0: return 32;   1: return 64;   2: return 192;  3: return 193;
      4: return 256;  5: return 320;  6: return 512;  default: return 600;
    endcase
  endfunction

  function automatic int pick(input int m);
    for (int i = 0; i < 8; i++) if (m == nom(i)) return i;
    for (int i = 0; i < 8; i++) if (m - nom(i) == 1 || nom(i) - m == 1) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; fsync_i = 1'b0; pwr_up_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(standby_o == 1'b1, "R1 standby", int'(standby_o), 1);
    chk(tick_o == 1'b0,    "R1 tick",    int'(tick_o), 0);
    chk(strobe_o == 1'b0,  "R1 strobe",  int'(strobe_o), 0);
    chk(locked_o == 1'b0,  "R1 locked",  int'(locked_o), 0);
    chk(tx_en_o == 1'b0,   "R1 tx_en",   int'(tx_en_o), 0);
    rst_ni = 1'b1;
    m_fsq = 0; m_armed = 0; m_locked = 0; m_sb = 1;
    m_cnt = 0; m_n = 0; m_idx = 0; m_k = 0; m_t = 0; m_r = 0;
  endtask

  task automatic step(input logic fs, input logic pu);
    bit    rise, lost, e_tick, e_strobe, no_match;
    int    p;
    string tick_tag, lock_tag, sb_tag, tx_tag;
    @(negedge clk_i);
    fsync_i = fs; pwr_up_i = pu;
    @(posedge clk_i);
    #1;
    rise = fs && !m_fsq; m_fsq = fs;
    lost = 0; e_tick = 0; e_strobe = 0; no_match = 0;
    tick_tag = "R5"; lock_tag = "R2"; sb_tag = "R9"; tx_tag = "R10";
    if (!pu) begin
      m_armed = 0; m_locked = 0; m_cnt = 0;
    end else if (rise) begin
      if (m_armed) begin
        p = pick(m_cnt + 1);
        m_locked = (p >= 0);
        if (p >= 0) begin m_idx = p; m_n = nom(p); end
        else begin no_match = 1; lock_tag = "R3"; tick_tag = "R3"; end
      end
      m_armed = 1; m_cnt = 0; m_k = 0;
      if (m_locked) begin e_tick = 1; e_strobe = 1; m_t = 1; end
    end else begin
      if (m_cnt < 1023) m_cnt++; else m_armed = 0;
      if (m_locked && m_cnt >= m_n + 8) begin lost = 1; m_locked = 0; lock_tag = "R7"; end
      m_k++;
      if (m_locked && ((32 * m_k) / m_n != (32 * (m_k - 1)) / m_n)) begin
        if (m_t < 32) begin e_tick = 1; m_t++; end
        else tick_tag = "R6";
      end
    end
    if (!pu || lost) begin
      m_sb = 1; m_r = 0;
    end else if (rise) begin
      if (m_sb) begin m_sb = 0; m_r = 0; end
      else if (m_r < 2) m_r++;
    end
    if (!pu) begin lock_tag = "R8"; sb_tag = "R8"; tx_tag = "R8"; tick_tag = "R8"; end
    if (lost) sb_tag = "R7";
    chk(tick_o == e_tick,       tick_tag, int'(tick_o), int'(e_tick));
    chk(strobe_o == e_strobe,   no_match ? "R3" : "R4", int'(strobe_o), int'(e_strobe));
    chk(locked_o == m_locked,   lock_tag, int'(locked_o), int'(m_locked));
    chk(standby_o == m_sb,      sb_tag, int'(standby_o), int'(m_sb));
    chk(tx_en_o == (!m_sb && m_r >= 2), tx_tag, int'(tx_en_o), int'(!m_sb && m_r >= 2));
    if (m_locked) chk(int'(rate_o) == m_idx, "R2 rate", int'(rate_o), m_idx);
  endtask

  task automatic frame(input int per, input logic pu);
    step(1'b1, pu);
    for (int j = 1; j < per; j++) step(1'b0, pu);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      do_reset();
      repeat (3) step(1'b0, 1'b1);
      repeat (3) frame(nom(i), 1'b1);       // wake, lock, tx permission
      frame(nom(i) + 1, 1'b1);              // tolerance and tick cap
      frame(nom(i) - 1, 1'b1);
      frame(nom(i), 1'b1);
      frame(nom(i) + 5, 1'b1);              // rejected period
      repeat (2) frame(nom(i), 1'b1);
      frame(nom(i) + 21, 1'b1);             // frame loss timeout inside
      repeat (3) frame(nom(i), 1'b1);       // recovery
      repeat (3) step(1'b0, 1'b0);          // power-down with an ignored edge
      step(1'b1, 1'b0);
      repeat (3) step(1'b0, 1'b0);
      repeat (3) frame(nom(i), 1'b1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_900_000;
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule